// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel beside a free-running timer counter. Each enabled timer tick it tests the counter value for equality with its active compare value. A hit sets a sticky match flag and drives a single waveform pin. In clear-on-match mode it also asks the counter to restart. Software writes the compare value through a write strobe. In the two PWM modes that write goes to a staging buffer, and the buffer moves into the active register only on the counter's top strobe, so a period never sees a half-updated threshold. In the other modes the write lands at once. A software force strobe can drive the pin as a hit would, without touching the flag or the counter. A write to the counter, signalled by a strobe, suppresses compare hits until one enabled tick has gone by.

The block holds four small state machines. The staging buffer machine has states BUF_SYNCED and BUF_PENDING: a PWM-mode write moves it to pending, a top strobe returns it to synced, and a direct write in a non-PWM mode also returns it to synced. The write guard has states GRD_OPEN and GRD_ARMED: a counter write arms it, and an enabled tick with no new write opens it again. The flag machine has states FLG_CLEAR and FLG_SET: a hit moves it to set, and a clear request without a simultaneous hit moves it back. The pin machine has states PIN_LOW and PIN_HIGH. It moves on set, clear and toggle actions, and a disconnected output field forces it to low.

Top module: `ocmp_channel`

## Requirements
- R1: In mode 00 (normal) and mode 10 (clear-on-match), a compare write updates `cmp_active` on the next clock.
- R2: In mode 01 (phase-correct PWM) and mode 11 (fast PWM), a compare write only stages the value. `cmp_active` takes the staged value on the clock after a `evt_top` pulse. `evt_bottom` does not update it.
- R3: A real hit needs `tick` high and `cnt_val` equal to `cmp_active` on all 8 bits. A hit sets `match_flag` on the next clock. The flag stays set until `flag_clr` is pulsed. With `tick` low, or with unequal values, there is no hit.
- R4: In modes 00 and 10, a hit applies output field `com_sel`: 01 toggles `wave_out`, 10 drives it low, 11 drives it high.
- R5: With `com_sel` = 00 in any mode, `wave_out` is low one clock later. In PWM modes, field 01 also holds it low.
- R6: In modes 00 and 10, `force_stb` applies the `com_sel` action to `wave_out`. It leaves `match_flag` and `cnt_clr_req` unchanged.
- R7: In PWM modes, `force_stb` has no effect on `wave_out` or `match_flag`.
- R8: In mode 10, a hit raises `cnt_clr_req` for exactly one clock, on the clock after the hit. It is never raised in the other modes.
- R9: A `cnt_wr` pulse suppresses hits in its own cycle and at the next `tick` cycle. The following `tick` cycle compares normally.
- R10: The suppression from `cnt_wr` lasts through any number of cycles without `tick`.
- R11: In PWM modes, field 10 drives `wave_out` low on a hit and high on `evt_bottom`. Field 11 does the opposite. A hit takes priority over `evt_bottom`.
- R12: A hit in the same cycle as `flag_clr` leaves `match_flag` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer clock enable; compares happen only when high |
| cnt_val | input | 8 | Current counter value |
| evt_top | input | 1 | Counter reached the top of its sequence |
| evt_bottom | input | 1 | Counter reached the bottom of its sequence |
| mode | input | 2 | 00 normal, 01 phase-correct PWM, 10 clear-on-match, 11 fast PWM |
| com_sel | input | 2 | Compare output field |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value write data |
| cnt_wr | input | 1 | Software wrote the counter in this cycle |
| force_stb | input | 1 | Force compare strobe |
| flag_clr | input | 1 | Clear the match flag |
| match_flag | output | 1 | Sticky compare match flag |
| wave_out | output | 1 | Waveform pin |
| cnt_clr_req | output | 1 | Request to clear the counter |
| cmp_active | output | 8 | Active compare value |

## Verification
The hardest case to reach is the write guard when the timer clock is stopped. The hit that should be lost arrives many cycles after the counter write, and by then no input still shows the write. The stimulus pulses `cnt_wr` with `tick` low, holds `cnt_val` equal to the compare value through several idle cycles, then gives two ticks. The flag must stay clear after the first tick and must set after the second. A second sequence writes the counter in the same cycle as a matching tick, which checks that the guard also covers its own cycle.

// File: rtl/ocmp_pkg.sv
`timescale 1ns/1ps
package ocmp_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_PWM_PC   = 2'b01,
        MODE_CTC      = 2'b10,
        MODE_PWM_FAST = 2'b11
    } ocmp_mode_e;

    typedef enum logic [1:0] {
        COM_OFF = 2'b00,
        COM_TGL = 2'b01,
        COM_CLR = 2'b10,
        COM_SET = 2'b11
    } ocmp_com_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_SET,
        ACT_CLR,
        ACT_TGL
    } pin_act_e;

    function automatic logic mode_is_pwm(input ocmp_mode_e m);
        logic r;
        unique case (m)
            MODE_PWM_PC, MODE_PWM_FAST: r = 1'b1;
            default:                    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ocmp_cmp_reg.sv
`timescale 1ns/1ps
module ocmp_cmp_reg
    import ocmp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          top,
    output logic [DW-1:0] active
);

    typedef enum logic {
        BUF_SYNCED,
        BUF_PENDING
    } buf_state_e;

    buf_state_e    state_q, state_d;
    logic [DW-1:0] act_q, act_d;
    logic [DW-1:0] stg_q, stg_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUF_SYNCED;
            act_q   <= '0;
            stg_q   <= '0;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
            stg_q   <= stg_d;
        end
    end

    always_comb begin
        state_d = state_q;
        act_d   = act_q;
        stg_d   = stg_q;
        unique case (state_q)
            BUF_SYNCED: begin
                if (!pwm && wr) begin
                    act_d = wdata;
                    stg_d = wdata;
                end else if (pwm && wr && top) begin
                    act_d = wdata;
                    stg_d = wdata;
                end else if (pwm && wr) begin
                    stg_d   = wdata;
                    state_d = BUF_PENDING;
                end
            end
            BUF_PENDING: begin
                if (!pwm && wr) begin
                    act_d   = wdata;
                    stg_d   = wdata;
                    state_d = BUF_SYNCED;
                end else if (pwm && top) begin
                    act_d   = wr ? wdata : stg_q;
                    stg_d   = wr ? wdata : stg_q;
                    state_d = BUF_SYNCED;
                end else if (pwm && wr) begin
                    stg_d = wdata;
                end
            end
            default: state_d = BUF_SYNCED;
        endcase
    end

    assign active = act_q;

endmodule

// File: rtl/ocmp_guard.sv
`timescale 1ns/1ps
module ocmp_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_wr,
    input  logic tick,
    output logic blocked
);

    typedef enum logic {
        GRD_OPEN,
        GRD_ARMED
    } grd_state_e;

    grd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GRD_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRD_OPEN:  if (cnt_wr) state_d = GRD_ARMED;
            GRD_ARMED: if (!cnt_wr && tick) state_d = GRD_OPEN;
            default:   state_d = GRD_OPEN;
        endcase
    end

    always_comb begin
        blocked = cnt_wr || (state_q == GRD_ARMED);
    end

endmodule

// File: rtl/ocmp_flag.sv
`timescale 1ns/1ps
module ocmp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    input  logic ctc,
    output logic flag,
    output logic clr_req
);

    typedef enum logic {
        FLG_CLEAR,
        FLG_SET
    } flg_state_e;

    flg_state_e state_q, state_d;
    logic       req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_CLEAR;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= hit && ctc;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: if (hit) state_d = FLG_SET;
            FLG_SET:   if (clr && !hit) state_d = FLG_CLEAR;
            default:   state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag    = (state_q == FLG_SET);
        clr_req = req_q;
    end

endmodule

// File: rtl/ocmp_wave.sv
`timescale 1ns/1ps
module ocmp_wave
    import ocmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm,
    input  logic [1:0] com,
    input  logic       hit,
    input  logic       force_hit,
    input  logic       bottom,
    output logic       wave
);

    typedef enum logic {
        PIN_LOW,
        PIN_HIGH
    } pin_state_e;

    pin_state_e state_q, state_d;
    pin_act_e   act;
    logic       park;
    ocmp_com_e  com_e;

    assign com_e = ocmp_com_e'(com);

    always_comb begin
        act  = ACT_NONE;
        park = 1'b0;
        if (!pwm) begin
            unique case (com_e)
                COM_OFF: park = 1'b1;
                COM_TGL: if (hit || force_hit) act = ACT_TGL;
                COM_CLR: if (hit || force_hit) act = ACT_CLR;
                COM_SET: if (hit || force_hit) act = ACT_SET;
                default: park = 1'b1;
            endcase
        end else begin
            unique case (com_e)
                COM_CLR: begin
                    if (hit)         act = ACT_CLR;
                    else if (bottom) act = ACT_SET;
                end
                COM_SET: begin
                    if (hit)         act = ACT_SET;
                    else if (bottom) act = ACT_CLR;
                end
                default: park = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LOW:  if (!park && (act == ACT_SET || act == ACT_TGL)) state_d = PIN_HIGH;
            PIN_HIGH: if (park || act == ACT_CLR || act == ACT_TGL)    state_d = PIN_LOW;
            default:  state_d = PIN_LOW;
        endcase
    end

    always_comb begin
        wave = (state_q == PIN_HIGH);
    end

endmodule

// File: rtl/ocmp_channel.sv
`timescale 1ns/1ps
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] cnt_val,
    input  logic          evt_top,
    input  logic          evt_bottom,
    input  logic [1:0]    mode,
    input  logic [1:0]    com_sel,
    input  logic          cmp_wr,
    input  logic [DW-1:0] cmp_wdata,
    input  logic          cnt_wr,
    input  logic          force_stb,
    input  logic          flag_clr,
    output logic          match_flag,
    output logic          wave_out,
    output logic          cnt_clr_req,
    output logic [DW-1:0] cmp_active
);

    ocmp_mode_e    mode_e;
    logic          pwm;
    logic          ctc;
    logic          blocked;
    logic          equal;
    logic          hit;
    logic          force_hit;

    assign mode_e    = ocmp_mode_e'(mode);
    assign pwm       = mode_is_pwm(mode_e);
    assign ctc       = (mode_e == MODE_CTC);
    assign equal     = (cnt_val == cmp_active);
    assign hit       = tick && equal && !blocked;
    assign force_hit = force_stb && !pwm;

    ocmp_cmp_reg #(.DW(DW)) cmp_reg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwm    (pwm),
        .wr     (cmp_wr),
        .wdata  (cmp_wdata),
        .top    (evt_top),
        .active (cmp_active)
    );

    ocmp_guard guard_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_wr  (cnt_wr),
        .tick    (tick),
        .blocked (blocked)
    );

    ocmp_flag flag_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr     (flag_clr),
        .ctc     (ctc),
        .flag    (match_flag),
        .clr_req (cnt_clr_req)
    );

    ocmp_wave wave_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm       (pwm),
        .com       (com_sel),
        .hit       (hit),
        .force_hit (force_hit),
        .bottom    (evt_bottom),
        .wave      (wave_out)
    );

endmodule

// File: rtl/ocmp_checker.sv
`timescale 1ns/1ps
module ocmp_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [1:0]    mode,
    input logic [1:0]    com_sel,
    input logic          cmp_wr,
    input logic          evt_top,
    input logic          force_stb,
    input logic          cnt_wr,
    input logic          flag_clr,
    input logic          match_flag,
    input logic          wave_out,
    input logic          cnt_clr_req,
    input logic [DW-1:0] cmp_active
);

    AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[0] && !cmp_wr) |=> $stable(cmp_active)); // R1

    AST_BUFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[0] && !evt_top) |=> $stable(cmp_active)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !flag_clr) |=> match_flag); // R3

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (com_sel == 2'b00) |=> !wave_out); // R5

    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stb && !tick && !match_flag) |=> !match_flag); // R6

    AST_CLR_ONLY_CTC: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_req |-> ($past(mode) == 2'b10)); // R8

    AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !match_flag) |=> !match_flag); // R9

endmodule

bind ocmp_channel ocmp_checker #(.DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .mode        (mode),
    .com_sel     (com_sel),
    .cmp_wr      (cmp_wr),
    .evt_top     (evt_top),
    .force_stb   (force_stb),
    .cnt_wr      (cnt_wr),
    .flag_clr    (flag_clr),
    .match_flag  (match_flag),
    .wave_out    (wave_out),
    .cnt_clr_req (cnt_clr_req),
    .cmp_active  (cmp_active)
);

// File: tb/ocmp_channel_tb_top.sv
`timescale 1ns/1ps
module ocmp_channel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cnt_val = 8'h00;
    logic       evt_top = 1'b0;
    logic       evt_bottom = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [1:0] com_sel = 2'b00;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'h00;
    logic       cnt_wr = 1'b0;
    logic       force_stb = 1'b0;
    logic       flag_clr = 1'b0;
    logic       match_flag;
    logic       wave_out;
    logic       cnt_clr_req;
    logic [7:0] cmp_active;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ocmp_channel dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val),
        .evt_top(evt_top), .evt_bottom(evt_bottom), .mode(mode),
        .com_sel(com_sel), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .cnt_wr(cnt_wr), .force_stb(force_stb), .flag_clr(flag_clr),
        .match_flag(match_flag), .wave_out(wave_out),
        .cnt_clr_req(cnt_clr_req), .cmp_active(cmp_active)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clk1();
        @(posedge clk);
        #1;
        tick = 0; evt_top = 0; evt_bottom = 0; cmp_wr = 0;
        cnt_wr = 0; force_stb = 0; flag_clr = 0;
    endtask

    task automatic wr_cmp(input logic [7:0] v);
        cmp_wr = 1; cmp_wdata = v; clk1();
    endtask

    task automatic clear_flag();
        flag_clr = 1; clk1();
    endtask

    task automatic t_reset();
        check("R3 reset flag", {7'b0, match_flag}, 8'h00);
        check("R5 reset wave", {7'b0, wave_out}, 8'h00);
        check("R8 reset clr_req", {7'b0, cnt_clr_req}, 8'h00);
        check("R1 reset cmp", cmp_active, 8'h00);
    endtask

    task automatic t_direct();
        mode = 2'b00; wr_cmp(8'h40);
        check("R1 normal direct write", cmp_active, 8'h40);
        mode = 2'b10; wr_cmp(8'h41);
        check("R1 ctc direct write", cmp_active, 8'h41);
        mode = 2'b00; wr_cmp(8'h40);
    endtask

    task automatic t_buffer();
        mode = 2'b11; wr_cmp(8'h80);
        check("R2 fast pwm staged", cmp_active, 8'h40);
        clk1(); clk1(); clk1();
        check("R2 held without top", cmp_active, 8'h40);
        evt_bottom = 1; clk1();
        check("R2 bottom no transfer", cmp_active, 8'h40);
        evt_top = 1; clk1();
        check("R2 top transfer", cmp_active, 8'h80);
        mode = 2'b01; wr_cmp(8'h90);
        check("R2 phase pwm staged", cmp_active, 8'h80);
        evt_top = 1; clk1();
        check("R2 phase pwm top transfer", cmp_active, 8'h90);
        mode = 2'b00; wr_cmp(8'h40);
        check("R1 back to direct", cmp_active, 8'h40);
    endtask

    task automatic t_match();
        mode = 2'b00; com_sel = 2'b00;
        cnt_val = 8'h40; clk1();
        check("R3 no tick no hit", {7'b0, match_flag}, 8'h00);
        cnt_val = 8'h41; tick = 1; clk1();
        check("R3 unequal no hit", {7'b0, match_flag}, 8'h00);
        cnt_val = 8'h40; tick = 1; clk1();
        check("R3 hit sets flag", {7'b0, match_flag}, 8'h01);
        cnt_val = 8'h41; tick = 1; clk1();
        check("R3 flag sticky", {7'b0, match_flag}, 8'h01);
        clear_flag();
        check("R3 flag cleared", {7'b0, match_flag}, 8'h00);
        cnt_val = 8'h40; tick = 1; flag_clr = 1; clk1();
        check("R12 set wins over clear", {7'b0, match_flag}, 8'h01);
        clear_flag();
    endtask

    task automatic t_com();
        mode = 2'b00; cnt_val = 8'h40;
        com_sel = 2'b01; tick = 1; clk1();
        check("R4 toggle high", {7'b0, wave_out}, 8'h01);
        tick = 1; clk1();
        check("R4 toggle low", {7'b0, wave_out}, 8'h00);
        com_sel = 2'b11; tick = 1; clk1();
        check("R4 set", {7'b0, wave_out}, 8'h01);
        com_sel = 2'b10; tick = 1; clk1();
        check("R4 clear", {7'b0, wave_out}, 8'h00);
        com_sel = 2'b11; tick = 1; clk1();
        com_sel = 2'b00; clk1();
        check("R5 off drives low", {7'b0, wave_out}, 8'h00);
        clear_flag();
    endtask

    task automatic t_force();
        mode = 2'b00; com_sel = 2'b01; cnt_val = 8'h10;
        force_stb = 1; clk1();
        check("R6 force toggles", {7'b0, wave_out}, 8'h01);
        check("R6 force no flag", {7'b0, match_flag}, 8'h00);
        mode = 2'b10; force_stb = 1; clk1();
        check("R6 force toggles in ctc", {7'b0, wave_out}, 8'h00);
        check("R6 force no clr_req", {7'b0, cnt_clr_req}, 8'h00);
        check("R6 force no flag in ctc", {7'b0, match_flag}, 8'h00);
    endtask

    task automatic t_force_pwm();
        mode = 2'b11; com_sel = 2'b11; cnt_val = 8'h10;
        force_stb = 1; clk1();
        check("R7 force ignored in pwm", {7'b0, wave_out}, 8'h00);
        check("R7 force no flag in pwm", {7'b0, match_flag}, 8'h00);
    endtask

    task automatic t_ctc();
        mode = 2'b10; com_sel = 2'b00; cnt_val = 8'h40;
        tick = 1; clk1();
        check("R8 ctc clr_req pulse", {7'b0, cnt_clr_req}, 8'h01);
        clk1();
        check("R8 clr_req one cycle", {7'b0, cnt_clr_req}, 8'h00);
        clear_flag();
        mode = 2'b00; tick = 1; clk1();
        check("R8 no clr_req in normal", {7'b0, cnt_clr_req}, 8'h00);
        clear_flag();
    endtask

    task automatic t_block();
        mode = 2'b00; cnt_val = 8'h40;
        com_sel = 2'b10; tick = 1; clk1();
        clear_flag();
        com_sel = 2'b01;
        cnt_wr = 1; clk1();
        tick = 1; clk1();
        check("R9 tick after write blocked flag", {7'b0, match_flag}, 8'h00);
        check("R9 tick after write blocked wave", {7'b0, wave_out}, 8'h00);
        tick = 1; clk1();
        check("R9 following tick matches", {7'b0, match_flag}, 8'h01);
        check("R9 following tick wave", {7'b0, wave_out}, 8'h01);
        clear_flag();
        cnt_wr = 1; tick = 1; clk1();
        check("R9 same cycle write blocked", {7'b0, match_flag}, 8'h00);
        tick = 1; clk1();
        check("R9 next tick still blocked", {7'b0, match_flag}, 8'h00);
        tick = 1; clk1();
        check("R9 then matches", {7'b0, match_flag}, 8'h01);
        clear_flag();
    endtask

    task automatic t_block_stopped();
        mode = 2'b00; com_sel = 2'b00; cnt_val = 8'h40;
        cnt_wr = 1; clk1();
        for (int i = 0; i < 6; i++) clk1();
        check("R10 idle no flag", {7'b0, match_flag}, 8'h00);
        tick = 1; clk1();
        check("R10 first tick blocked", {7'b0, match_flag}, 8'h00);
        tick = 1; clk1();
        check("R10 second tick matches", {7'b0, match_flag}, 8'h01);
        clear_flag();
    endtask

    task automatic t_pwm_wave();
        mode = 2'b11; com_sel = 2'b10;
        evt_bottom = 1; clk1();
        check("R11 bottom sets", {7'b0, wave_out}, 8'h01);
        cnt_val = 8'h20; tick = 1; clk1();
        check("R11 no hit holds", {7'b0, wave_out}, 8'h01);
        cnt_val = 8'h40; tick = 1; clk1();
        check("R11 hit clears", {7'b0, wave_out}, 8'h00);
        com_sel = 2'b11; tick = 1; evt_bottom = 1; clk1();
        check("R11 hit beats bottom", {7'b0, wave_out}, 8'h01);
        evt_bottom = 1; clk1();
        check("R11 inverted bottom clears", {7'b0, wave_out}, 8'h00);
        com_sel = 2'b01; tick = 1; clk1();
        check("R5 pwm field 01 low", {7'b0, wave_out}, 8'h00);
        clear_flag();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        clk1();
        t_reset();
        t_direct();
        t_buffer();
        t_match();
        t_com();
        t_force();
        t_force_pwm();
        t_ctc();
        t_block();
        t_block_stopped();
        t_pwm_wave();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule